// File: doc/BRIEF.md
# Auxiliary System Control Register Bank

This block is a small bank of memory-mapped control registers for a workstation I/O chip. It holds byte-wide configuration, diagnostic, modem-control and two auxiliary registers, a 16-bit diagnostic LED register and a byte-wide system control register. A simple synchronous register bus drives it. The bus has a one-hot register select, a write enable, a two-bit byte offset and 32-bit write data. Read data comes back combinationally from whichever register is selected.

The block watches a power-fail input and raises a power-fail interrupt when the interrupt is enabled. Software can acknowledge the condition through the second auxiliary register. The block also produces three single-cycle requests: a floppy terminal-count strobe, a power-off request and a system reset request.

There are two synchronous active-low resets. A soft reset clears only the working registers. A power-on reset clears everything, including the diagnostic, LED and system control registers.

Top module: `auxio_ctl_bank`

## Requirements
- R1: `pfail_irq` is high exactly when the power-fail flag (AUX2 bit 5) and the interrupt enable (config bit 3) are both set. It follows every config write, AUX2 write and flag update on the next cycle.
- R2: When `pwr_fail_in` differs from its value in the previous cycle, the power-fail flag becomes 1 if the input is high and config bit 3 is set. Otherwise the flag becomes 0.
- R3: A write to AUX1 (select bit 5) with data bit 1 set gives `fd_tc_pulse` high for exactly the next cycle. AUX1 stores the written byte with bit 1 forced to 0.
- R4: A write to AUX2 (select bit 6) stores data bit 0 and keeps the current power-fail flag. It stores no other written bits. When data bit 1 is set, the flag is cleared.
- R5: A write to AUX2 with data bit 0 set gives `pwr_off_req` high for exactly the next cycle. Any other AUX2 write leaves it low.
- R6: A write to system control (select bit 4) at offset 0 with data bit 0 set loads 0x02 and gives `sys_rst_req` high for exactly the next cycle. Writes at other offsets, or without bit 0, change nothing.
- R7: A system control read returns the stored byte at offset 0 and zero at offsets 1 to 3.
- R8: A soft reset (`rst_n` low) clears config, AUX1, AUX2 and modem control. It keeps the diagnostic, LED and system control registers.
- R9: Config (select bit 0), diagnostic (bit 1) and modem control (bit 2) are 8-bit read/write registers. LED (bit 3) is a 16-bit read/write register. Reads are zero-extended to 32 bits, and a read with no select bit set returns zero.
- R10: A power-on reset (`por_n` low) clears every register, including diagnostic, LED and system control.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low soft reset |
| por_n | input | 1 | Synchronous active-low power-on reset |
| sel | input | 7 | One-hot register select |
| wr_en | input | 1 | Write strobe for the selected register |
| addr | input | 2 | Byte offset inside the system control window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the selected register |
| pwr_fail_in | input | 1 | Power-fail sense input |
| pfail_irq | output | 1 | Power-fail interrupt |
| fd_tc_pulse | output | 1 | Floppy terminal-count strobe |
| pwr_off_req | output | 1 | Power-off request pulse |
| sys_rst_req | output | 1 | System reset request pulse |

## Verification
Read data is combinational, so the bench expects it in the cycle in which the select is driven. The three request pulses, the interrupt and each power-fail flag update are due one cycle after the write or input change that causes them. Each request pulse is also expected to be low again one cycle later. The driver records the cycle of each stimulus and queues every expected value with its due cycle. The monitor compares each entry half a cycle away from the clock edge, and it counts an entry that finds no matching cycle as a failure.

// File: rtl/auxio_pkg.sv
// Shared constants for the auxiliary system control bank: select
// indices, field bit positions and fixed register values.
package auxio_pkg;
    localparam int NUM_SEL    = 7;
    localparam int SEL_CFG    = 0;
    localparam int SEL_DIAG   = 1;
    localparam int SEL_MODEM  = 2;
    localparam int SEL_LED    = 3;
    localparam int SEL_SYSCTL = 4;
    localparam int SEL_AUX1   = 5;
    localparam int SEL_AUX2   = 6;

    localparam int REG_W      = 8;
    localparam int CFG_IEN    = 3;   // power interrupt enable
    localparam int AUX1_TC    = 1;   // terminal-count strobe bit
    localparam int AUX2_OFF   = 0;   // power-off request bit
    localparam int AUX2_CLR   = 1;   // flag acknowledge bit
    localparam int AUX2_PF    = 5;   // power-fail flag bit
    localparam int SYS_GO     = 0;   // reset trigger bit
    localparam logic [REG_W-1:0] SYS_DONE = 8'h02;
endpackage

// File: rtl/auxio_plain_regs.sv
// Bank of NUM plain read/write registers of width W.
// Assumes: sel is one-hot, rst_n and por_n are synchronous active-low.
// A register is cleared by soft reset only if its SOFT_MASK bit is set.
module auxio_plain_regs #(
    parameter int W = 8,
    parameter int NUM = 3,
    parameter logic [NUM-1:0] SOFT_MASK = '1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   por_n,
    input  logic                   wr_en,
    input  logic [NUM-1:0]         sel,
    input  logic [W-1:0]           wdata,
    output logic [NUM-1:0][W-1:0]  q
);
    for (genvar g = 0; g < NUM; g++) begin : g_reg
        logic [W-1:0] r;
        // hold or load one register
        always_ff @(posedge clk) begin
            if (!por_n || (!rst_n && SOFT_MASK[g]))
                r <= '0;
            else if (wr_en && sel[g])
                r <= wdata;
        end
        assign q[g] = r;
    end
endmodule

// File: rtl/auxio_aux1.sv
// First auxiliary register: stores written bytes with the strobe bit
// masked off and turns a set strobe bit into a one-cycle pulse.
// Assumes: wr is already qualified by the select.
module auxio_aux1 (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        por_n,
    input  logic                        wr,
    input  logic [auxio_pkg::REG_W-1:0] wdata,
    output logic [auxio_pkg::REG_W-1:0] q,
    output logic                        tc_pulse
);
    import auxio_pkg::*;
    localparam logic [REG_W-1:0] KEEP = ~(REG_W'(1) << AUX1_TC);

    // register update and strobe generation
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            q        <= '0;
            tc_pulse <= 1'b0;
        end else begin
            tc_pulse <= wr && wdata[AUX1_TC];
            if (wr)
                q <= wdata & KEEP;
        end
    end
endmodule

// File: rtl/auxio_aux2_power.sv
// Second auxiliary register with power-fail tracking. It keeps the
// power-fail flag, acknowledges it on request, issues power-off pulses
// and drives the interrupt.
// Assumes: wr is already qualified by the select; pf_in is synchronous.
module auxio_aux2_power (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        por_n,
    input  logic                        wr,
    input  logic [auxio_pkg::REG_W-1:0] wdata,
    input  logic                        ien,
    input  logic                        pf_in,
    output logic [auxio_pkg::REG_W-1:0] q,
    output logic                        irq,
    output logic                        off_req
);
    import auxio_pkg::*;
    logic             pf_prev;
    logic             pf_bit;
    logic [REG_W-1:0] nxt;

    // next register value from input change and software write
    always_comb begin
        pf_bit = (pf_in != pf_prev) ? (pf_in && ien) : q[AUX2_PF];
        nxt = q;
        nxt[AUX2_PF] = pf_bit;
        if (wr) begin
            nxt = '0;
            nxt[AUX2_OFF] = wdata[AUX2_OFF];
            nxt[AUX2_PF]  = wdata[AUX2_CLR] ? 1'b0 : pf_bit;
        end
    end

    // state registers and power-off pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n) begin
            q       <= '0;
            pf_prev <= 1'b0;
            off_req <= 1'b0;
        end else begin
            q       <= nxt;
            pf_prev <= pf_in;
            off_req <= wr && wdata[AUX2_OFF];
        end
    end

    // interrupt from the stored flag and the enable
    always_comb irq = q[AUX2_PF] && ien;
endmodule

// File: rtl/auxio_sysctl.sv
// System control register: a trigger write loads the done value and
// requests a system reset for one cycle. Only offset 0 is backed.
// Assumes: wr is already qualified by the select.
module auxio_sysctl #(
    parameter int OFS_W = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        por_n,
    input  logic                        wr,
    input  logic [OFS_W-1:0]            addr,
    input  logic                        go,
    output logic [auxio_pkg::REG_W-1:0] rd_val,
    output logic                        rst_req
);
    import auxio_pkg::*;
    logic [REG_W-1:0] q;
    logic             hit;

    // trigger decode: offset 0 with the go bit
    always_comb hit = wr && (addr == '0) && go;

    // stored value survives soft reset
    always_ff @(posedge clk) begin
        if (!por_n)
            q <= '0;
        else if (hit)
            q <= SYS_DONE;
    end

    // reset request pulse
    always_ff @(posedge clk) begin
        if (!rst_n || !por_n)
            rst_req <= 1'b0;
        else
            rst_req <= hit;
    end

    // read: offset 0 only, others zero
    always_comb rd_val = (addr == '0) ? q : '0;
endmodule

// File: rtl/auxio_ctl_bank.sv
// Top of the auxiliary system control bank. It decodes the one-hot
// select, instantiates the register groups and multiplexes read data.
// Assumes: sel is one-hot or zero; both resets are synchronous.
module auxio_ctl_bank #(
    parameter int BUS_W = 32,
    parameter int OFS_W = 2,
    parameter int LED_W = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          por_n,
    input  logic [auxio_pkg::NUM_SEL-1:0] sel,
    input  logic                          wr_en,
    input  logic [OFS_W-1:0]              addr,
    input  logic [BUS_W-1:0]              wdata,
    output logic [BUS_W-1:0]              rdata,
    input  logic                          pwr_fail_in,
    output logic                          pfail_irq,
    output logic                          fd_tc_pulse,
    output logic                          pwr_off_req,
    output logic                          sys_rst_req
);
    import auxio_pkg::*;
    localparam int NBYTE = 3;

    logic [NBYTE-1:0][REG_W-1:0] byte_q;
    logic [0:0][LED_W-1:0]       led_q;
    logic [REG_W-1:0]            aux1_q, aux2_q, sys_rd;
    logic [REG_W-1:0]            cfg_q;

    auxio_plain_regs #(.W(REG_W), .NUM(NBYTE), .SOFT_MASK(3'b101)) u_bytes (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .sel({sel[SEL_MODEM], sel[SEL_DIAG], sel[SEL_CFG]}),
        .wdata(wdata[REG_W-1:0]), .q(byte_q)
    );
    assign cfg_q = byte_q[0];

    auxio_plain_regs #(.W(LED_W), .NUM(1), .SOFT_MASK(1'b0)) u_led (
        .clk(clk), .rst_n(rst_n), .por_n(por_n), .wr_en(wr_en),
        .sel(sel[SEL_LED]), .wdata(wdata[LED_W-1:0]), .q(led_q)
    );

    auxio_aux1 u_aux1 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr(wr_en && sel[SEL_AUX1]), .wdata(wdata[REG_W-1:0]),
        .q(aux1_q), .tc_pulse(fd_tc_pulse)
    );

    auxio_aux2_power u_aux2 (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr(wr_en && sel[SEL_AUX2]), .wdata(wdata[REG_W-1:0]),
        .ien(cfg_q[CFG_IEN]), .pf_in(pwr_fail_in),
        .q(aux2_q), .irq(pfail_irq), .off_req(pwr_off_req)
    );

    auxio_sysctl #(.OFS_W(OFS_W)) u_sys (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .wr(wr_en && sel[SEL_SYSCTL]), .addr(addr), .go(wdata[SYS_GO]),
        .rd_val(sys_rd), .rst_req(sys_rst_req)
    );

    // OR-multiplexed, zero-extended read data
    always_comb begin
        rdata = '0;
        if (sel[SEL_CFG])    rdata = rdata | BUS_W'(byte_q[0]);
        if (sel[SEL_DIAG])   rdata = rdata | BUS_W'(byte_q[1]);
        if (sel[SEL_MODEM])  rdata = rdata | BUS_W'(byte_q[2]);
        if (sel[SEL_LED])    rdata = rdata | BUS_W'(led_q[0]);
        if (sel[SEL_SYSCTL]) rdata = rdata | BUS_W'(sys_rd);
        if (sel[SEL_AUX1])   rdata = rdata | BUS_W'(aux1_q);
        if (sel[SEL_AUX2])   rdata = rdata | BUS_W'(aux2_q);
    end
endmodule

// File: rtl/auxio_ctl_bank_chk.sv
// Checker for the auxiliary system control bank, attached by bind.
// It relates bus stimulus to outputs one cycle later.
module auxio_ctl_bank_chk #(
    parameter int BUS_W = 32,
    parameter int OFS_W = 2
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          por_n,
    input logic [auxio_pkg::NUM_SEL-1:0] sel,
    input logic                          wr_en,
    input logic [OFS_W-1:0]              addr,
    input logic [BUS_W-1:0]              wdata,
    input logic [BUS_W-1:0]              rdata,
    input logic                          pfail_irq,
    input logic                          fd_tc_pulse,
    input logic                          pwr_off_req,
    input logic                          sys_rst_req
);
    import auxio_pkg::*;

    p_tc_on_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && sel[SEL_AUX1] && wdata[AUX1_TC]) |=> fd_tc_pulse);
    p_tc_off_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(wr_en && sel[SEL_AUX1] && wdata[AUX1_TC]) |=> !fd_tc_pulse);
    p_aux1_bit_r3: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (sel == (NUM_SEL'(1) << SEL_AUX1)) |-> !rdata[AUX1_TC]);
    p_off_on_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && sel[SEL_AUX2] && wdata[AUX2_OFF]) |=> pwr_off_req);
    p_off_off_r5: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(wr_en && sel[SEL_AUX2] && wdata[AUX2_OFF]) |=> !pwr_off_req);
    p_ack_r4: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && sel[SEL_AUX2] && wdata[AUX2_CLR]) |=> !pfail_irq);
    p_ien_r1: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && sel[SEL_CFG] && !wdata[CFG_IEN]) |=> !pfail_irq);
    p_rst_on_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (wr_en && sel[SEL_SYSCTL] && addr == '0 && wdata[SYS_GO]) |=> sys_rst_req);
    p_rst_off_r6: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        !(wr_en && sel[SEL_SYSCTL] && addr == '0 && wdata[SYS_GO]) |=> !sys_rst_req);
    p_sys_hi_r7: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (sel == (NUM_SEL'(1) << SEL_SYSCTL) && addr != '0) |-> rdata == '0);
    p_nosel_r9: assert property (@(posedge clk) disable iff (!rst_n || !por_n)
        (sel == '0) |-> rdata == '0);
endmodule

bind auxio_ctl_bank auxio_ctl_bank_chk #(.BUS_W(BUS_W), .OFS_W(OFS_W)) u_chk (.*);

// File: tb/sim_auxio_ctl_bank.sv
`timescale 1ns/1ps
// Scoreboard bench: driver tasks queue expected values with due cycles,
// a monitor compares them half a cycle after the clock edge.
module sim_auxio_ctl_bank;
    import auxio_pkg::*;

    localparam int K_RD = 0, K_IRQ = 1, K_TC = 2, K_OFF = 3, K_RST = 4;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0, por_n = 1'b0;
    logic [NUM_SEL-1:0] sel = '0;
    logic               wr_en = 1'b0;
    logic [1:0]         addr = '0;
    logic [31:0]        wdata = '0;
    logic [31:0]        rdata;
    logic               pwr_fail_in = 1'b0;
    logic               pfail_irq, fd_tc_pulse, pwr_off_req, sys_rst_req;

    auxio_ctl_bank u0 (.*);

    always #4 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int          due;
        int          kind;
        logic [31:0] exp;
        string       req;
    } exp_t;
    exp_t        sbq[$];
    int          n_chk = 0, n_err = 0;
    bit          done = 1'b0;
    logic [31:0] got;

    task automatic expect_at(int due, int kind, logic [31:0] e, string r);
        exp_t it;
        it.due = due; it.kind = kind; it.exp = e; it.req = r;
        sbq.push_back(it);
    endtask

    function automatic logic [31:0] sample(int kind);
        case (kind)
            K_RD:    return rdata;
            K_IRQ:   return {31'b0, pfail_irq};
            K_TC:    return {31'b0, fd_tc_pulse};
            K_OFF:   return {31'b0, pwr_off_req};
            default: return {31'b0, sys_rst_req};
        endcase
    endfunction

    // monitor: compare due entries away from the clock edge
    initial forever begin
        @(negedge clk);
        #2;
        for (int i = sbq.size() - 1; i >= 0; i--) begin
            if (sbq[i].due <= cyc) begin
                n_chk++;
                got = sample(sbq[i].kind);
                if (sbq[i].due < cyc || got !== sbq[i].exp) begin
                    n_err++;
                    $display("FAIL %s kind=%0d cycle=%0d: got %h expected %h",
                             sbq[i].req, sbq[i].kind, cyc, got, sbq[i].exp);
                end
                sbq.delete(i);
            end
        end
    end

    function automatic logic [NUM_SEL-1:0] onehot(int idx);
        return (idx < 0) ? '0 : (NUM_SEL'(1) << idx);
    endfunction

    task automatic wr(int idx, logic [1:0] a, logic [31:0] d, output int at);
        @(negedge clk);
        sel = onehot(idx); wr_en = 1'b1; addr = a; wdata = d;
        at = cyc;
    endtask

    task automatic rd(int idx, logic [1:0] a, logic [31:0] e, string r);
        @(negedge clk);
        sel = onehot(idx); wr_en = 1'b0; addr = a; wdata = '0;
        expect_at(cyc, K_RD, e, r);
    endtask

    task automatic set_pf(logic v, output int at);
        @(negedge clk);
        sel = '0; wr_en = 1'b0; pwr_fail_in = v;
        at = cyc;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
        end
    end

    // stimulus
    initial begin
        int t;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; por_n = 1'b1;

        // R10: power-on reset clears every register
        rd(SEL_CFG, 0, 32'h0, "R10 cfg");
        rd(SEL_DIAG, 0, 32'h0, "R10 diag");
        rd(SEL_LED, 0, 32'h0, "R10 led");
        rd(SEL_SYSCTL, 0, 32'h0, "R10 sysctl");
        rd(SEL_AUX2, 0, 32'h0, "R10 aux2");
        expect_at(cyc, K_IRQ, 0, "R1 irq after reset");

        // R9: plain registers and zero extension
        wr(SEL_CFG, 0, 32'hFFFF_FFA5, t);
        wr(SEL_DIAG, 0, 32'h1234_563C, t);
        wr(SEL_MODEM, 0, 32'h0000_0081, t);
        wr(SEL_LED, 0, 32'hAAAA_BEEF, t);
        rd(SEL_CFG, 0, 32'hA5, "R9 cfg");
        rd(SEL_DIAG, 0, 32'h3C, "R9 diag");
        rd(SEL_MODEM, 0, 32'h81, "R9 modem");
        rd(SEL_LED, 0, 32'hBEEF, "R9 led");
        rd(-1, 0, 32'h0, "R9 no select");

        // R3: terminal-count strobe and masked store
        wr(SEL_AUX1, 0, 32'hFF, t);
        expect_at(t + 1, K_TC, 1, "R3 tc pulse");
        expect_at(t + 2, K_TC, 0, "R3 tc one cycle");
        rd(SEL_AUX1, 0, 32'hFD, "R3 aux1 bit1 stored 0");
        rd(SEL_AUX1, 0, 32'hFD, "R3 aux1 hold");
        wr(SEL_AUX1, 0, 32'h01, t);
        expect_at(t + 1, K_TC, 0, "R3 no tc without bit1");
        rd(SEL_AUX1, 0, 32'h01, "R3 aux1 plain");

        // R1 R2: power-fail flag with interrupt enabled
        wr(SEL_CFG, 0, 32'h08, t);
        set_pf(1'b1, t);
        expect_at(t + 1, K_IRQ, 1, "R1 irq raised");
        rd(SEL_AUX2, 0, 32'h20, "R2 flag set");

        // R4: acknowledge clears flag and interrupt
        wr(SEL_AUX2, 0, 32'h02, t);
        expect_at(t + 1, K_IRQ, 0, "R4 irq dropped");
        expect_at(t + 1, K_OFF, 0, "R5 no off on ack");
        rd(SEL_AUX2, 0, 32'h00, "R4 aux2 cleared");
        rd(SEL_AUX2, 0, 32'h00, "R2 no change no flag");

        set_pf(1'b0, t);
        set_pf(1'b1, t);
        expect_at(t + 1, K_IRQ, 1, "R2 flag on new rise");

        // R1: disabling the enable drops the interrupt, flag stays
        wr(SEL_CFG, 0, 32'h00, t);
        expect_at(t + 1, K_IRQ, 0, "R1 enable off");
        rd(SEL_AUX2, 0, 32'h20, "R1 flag retained");
        wr(SEL_CFG, 0, 32'h08, t);
        expect_at(t + 1, K_IRQ, 1, "R1 enable on");

        // R5: power-off request
        wr(SEL_AUX2, 0, 32'h01, t);
        expect_at(t + 1, K_OFF, 1, "R5 off pulse");
        expect_at(t + 2, K_OFF, 0, "R5 off one cycle");
        expect_at(t + 1, K_IRQ, 1, "R4 flag kept on write");
        rd(SEL_AUX2, 0, 32'h21, "R4 aux2 merge");
        rd(SEL_AUX2, 0, 32'h21, "R4 aux2 hold");

        // R2: flag update with enable clear
        wr(SEL_CFG, 0, 32'h00, t);
        set_pf(1'b0, t);
        set_pf(1'b1, t);
        rd(SEL_AUX2, 0, 32'h01, "R2 no flag when disabled");
        expect_at(cyc, K_IRQ, 0, "R1 irq low disabled");

        // R4: other written bits are not stored
        wr(SEL_AUX2, 0, 32'hFC, t);
        expect_at(t + 1, K_OFF, 0, "R5 no off without bit0");
        rd(SEL_AUX2, 0, 32'h00, "R4 upper bits dropped");

        // R6 R7: system control
        wr(SEL_SYSCTL, 1, 32'h01, t);
        expect_at(t + 1, K_RST, 0, "R6 offset 1 ignored");
        rd(SEL_SYSCTL, 0, 32'h0, "R6 offset 1 no store");
        wr(SEL_SYSCTL, 0, 32'hFE, t);
        expect_at(t + 1, K_RST, 0, "R6 no go bit");
        rd(SEL_SYSCTL, 0, 32'h0, "R6 no go no store");
        wr(SEL_SYSCTL, 0, 32'h01, t);
        expect_at(t + 1, K_RST, 1, "R6 reset pulse");
        expect_at(t + 2, K_RST, 0, "R6 reset one cycle");
        rd(SEL_SYSCTL, 0, 32'h02, "R7 offset 0 value");
        rd(SEL_SYSCTL, 3, 32'h0, "R7 offset 3 zero");
        rd(SEL_SYSCTL, 2, 32'h0, "R7 offset 2 zero");

        // R8: soft reset scope
        wr(SEL_MODEM, 0, 32'h5A, t);
        wr(SEL_CFG, 0, 32'h0F, t);
        @(negedge clk);
        sel = '0; wr_en = 1'b0; rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd(SEL_CFG, 0, 32'h0, "R8 cfg cleared");
        rd(SEL_MODEM, 0, 32'h0, "R8 modem cleared");
        rd(SEL_AUX1, 0, 32'h0, "R8 aux1 cleared");
        rd(SEL_AUX2, 0, 32'h0, "R8 aux2 cleared");
        rd(SEL_DIAG, 0, 32'h3C, "R8 diag kept");
        rd(SEL_LED, 0, 32'hBEEF, "R8 led kept");
        rd(SEL_SYSCTL, 0, 32'h02, "R8 sysctl kept");

        @(negedge clk);
        sel = '0;
        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            n_chk++; n_err++;
            $display("FAIL scoreboard: got %0d pending expected 0", sbq.size());
        end
        done = 1'b1;
        summary();
    end
endmodule